// File: doc/BRIEF.md
# Phase-Frequency Detector with Pump/Pin Output Steering

This block compares the rising edges of two divided clocks: `fc_in`, derived from the reference, and `fp_in`, derived from the oscillator feedback. Both are brought into the block's fast clock domain. A four-state detector machine turns the edge order into active-low "up" and "down" pulses. The edge that arrives first opens its pulse. The second edge opens the other pulse. After a short fixed overlap both pulses are cleared together. This anti-backlash overlap keeps the loop linear near zero phase error.

A select input chooses where the result goes. When it is high, a digital charge-pump drive is enabled and both discrete pulse pins are forced low. When it is low, the pump drive is idle and not enabled, and the pins carry the pulses. A raw phase-error flag is the NAND of the two internal active-low pulses. A lock filter reports lock through a pull-low enable. The filter needs a run of consecutive comparison cycles in which neither lead phase is longer than a programmable width. Any over-wide lead drops lock at once and restarts the count.

Detector states: `DET_IDLE`, `DET_UP_LEAD`, `DET_DN_LEAD`, `DET_OVERLAP`. Transitions:
- IDLE→UP_LEAD on an fc edge alone.
- IDLE→DN_LEAD on an fp edge alone.
- IDLE→OVERLAP on both edges in the same cycle.
- UP_LEAD→OVERLAP on an fp edge.
- DN_LEAD→OVERLAP on an fc edge.
- OVERLAP→IDLE when the overlap counter expires. This is the "compare done" event.

Lock states: `LK_HUNT` and `LK_LOCKED`. HUNT→LOCKED happens when a compare-done event brings the clean-comparison count to `LOCK_CYCLES`. LOCKED→HUNT happens on an over-wide lead.

Top module: `pfd_steer`

## Requirements
- R1: After reset, with `pump_sel` low, `up_n` and `dn_n` are 1, `pump_oe` is 0, `pump_drive` is idle (2'b00), `phase_err` is 0 and `ld_pull_low` is 1.
- R2: If an fc rising edge is seen G cycles before the fp edge, the up pulse is active for G+`RST_DLY` cycles. With `pump_sel` high, `pump_drive` is source (2'b11) for exactly G cycles.
- R3: If an fp rising edge is seen G cycles before the fc edge, the down pulse is active for G+`RST_DLY` cycles. With `pump_sel` high, `pump_drive` is sink (2'b10) for exactly G cycles.
- R4: The second edge of a comparison makes both pulses active for exactly `RST_DLY` cycles, after which both clear. Edges seen in the same cycle give only the `RST_DLY`-cycle overlap on both pulses.
- R5: While `pump_sel` is high, `up_n` and `dn_n` are 0 and `pump_oe` is 1.
- R6: While `pump_sel` is low, `pump_oe` is 0 and `pump_drive` is idle (2'b00). `up_n` and `dn_n` are then the active-low pulses.
- R7: `phase_err` is high exactly when either internal active-low pulse is low (their NAND), whatever the value of `pump_sel`.
- R8: `ld_pull_low` falls to 0 only at the end of the `LOCK_CYCLES`-th consecutive comparison whose lead phase lasted no more than `pulse_limit` cycles.
- R9: A lead phase longer than `pulse_limit` cycles drives `ld_pull_low` to 1 on the next cycle and clears the clean-comparison count. The comparison that contains it does not count.
- R10: The `pump_drive` encoding is {enable, direction}. Idle is 2'b00, sink is 2'b10 and source is 2'b11. The value 2'b01 never appears. Both pulses active together give idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fc_in | input | 1 | Reference-derived divided clock |
| fp_in | input | 1 | Feedback-derived divided clock |
| pump_sel | input | 1 | 1: pump drive enabled, pins forced low; 0: pins carry pulses |
| pulse_limit | input | PW_W | Longest lead phase, in cycles, still counted as clean |
| up_n | output | 1 | Active-low up pulse pin |
| dn_n | output | 1 | Active-low down pulse pin |
| pump_oe | output | 1 | Charge-pump drive enable (0 models tri-state) |
| pump_drive | output | 2 | {enable, direction} pump command |
| phase_err | output | 1 | NAND of the internal active-low pulses |
| ld_pull_low | output | 1 | 1: lock output pulled low (unlocked); 0: released |

## Verification
A detector state that fails to leave a lead phase shows up as an up or down pulse that never ends. Within `pulse_limit` plus one cycles the same fault raises `ld_pull_low` again. An overlap counter that is off by one changes the pulse length of both outputs on every comparison, so a single comparison reveals it by its pulse-width count. A wrong count in the lock filter only moves the cycle at which `ld_pull_low` is released. That cycle is compared against `LOCK_CYCLES` clean comparisons, and against a restart after an over-wide lead.

// File: rtl/pfd_steer_pkg.sv
package pfd_steer_pkg;

    // Pump command: {enable, direction}
    typedef enum logic [1:0] {
        PUMP_IDLE   = 2'b00,
        PUMP_SINK   = 2'b10,
        PUMP_SOURCE = 2'b11
    } pump_t;

    typedef enum logic [1:0] {
        DET_IDLE    = 2'b00,
        DET_UP_LEAD = 2'b01,
        DET_DN_LEAD = 2'b10,
        DET_OVERLAP = 2'b11
    } det_state_t;

    typedef enum logic {
        LK_HUNT   = 1'b0,
        LK_LOCKED = 1'b1
    } lock_state_t;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int TAPS = SYNC_STAGES + 1;

    logic [TAPS-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[TAPS-2:0], din};
        end
    end

    // newest synchronised sample high, one older still low
    assign rise = chain[TAPS-2] & ~chain[TAPS-1];

endmodule

// File: rtl/pfd_detector.sv
module pfd_detector
    import pfd_steer_pkg::*;
#(
    parameter int RST_DLY = 2,
    parameter int PW_W    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fc_rise,
    input  logic            fp_rise,
    input  logic [PW_W-1:0] pulse_limit,
    output logic            up_act,
    output logic            dn_act,
    output logic            cmp_done,
    output logic            too_wide
);
    localparam int DLY_W = (RST_DLY < 2) ? 1 : $clog2(RST_DLY);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(RST_DLY - 1);
    localparam int LEAD_W = PW_W + 1;
    localparam logic [LEAD_W-1:0] LEAD_MAX = '1;

    det_state_t        state, state_n;
    logic [DLY_W-1:0]  dly_cnt;
    logic [LEAD_W-1:0] lead_cnt;
    logic              in_lead;
    logic              dly_done;

    assign in_lead  = (state == DET_UP_LEAD) || (state == DET_DN_LEAD);
    assign dly_done = (state == DET_OVERLAP) && (dly_cnt == DLY_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DET_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            DET_IDLE: begin
                if (fc_rise && fp_rise) state_n = DET_OVERLAP;
                else if (fc_rise)       state_n = DET_UP_LEAD;
                else if (fp_rise)       state_n = DET_DN_LEAD;
            end
            DET_UP_LEAD: if (fp_rise) state_n = DET_OVERLAP;
            DET_DN_LEAD: if (fc_rise) state_n = DET_OVERLAP;
            DET_OVERLAP: if (dly_done) state_n = DET_IDLE;
        endcase
    end

    // overlap delay and lead-width counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_cnt  <= '0;
            lead_cnt <= '0;
        end else begin
            dly_cnt <= (state == DET_OVERLAP) ? dly_cnt + 1'b1 : '0;
            if (!in_lead) begin
                lead_cnt <= '0;
            end else if (lead_cnt != LEAD_MAX) begin
                lead_cnt <= lead_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        up_act   = (state == DET_UP_LEAD) || (state == DET_OVERLAP);
        dn_act   = (state == DET_DN_LEAD) || (state == DET_OVERLAP);
        cmp_done = dly_done;
        too_wide = in_lead && (lead_cnt >= {1'b0, pulse_limit});
    end

endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter
    import pfd_steer_pkg::*;
#(
    parameter int LOCK_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_done,
    input  logic too_wide,
    output logic locked
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LOCK_CYCLES);

    lock_state_t      state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             wide_seen, wide_seen_n;
    logic             clean_done;

    assign clean_done = cmp_done && !wide_seen;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= LK_HUNT;
            cnt       <= '0;
            wide_seen <= 1'b0;
        end else begin
            state     <= state_n;
            cnt       <= cnt_n;
            wide_seen <= wide_seen_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n     = state;
        cnt_n       = cnt;
        wide_seen_n = too_wide ? 1'b1 : (cmp_done ? 1'b0 : wide_seen);
        unique case (state)
            LK_HUNT: begin
                if (too_wide) begin
                    cnt_n = '0;
                end else if (clean_done) begin
                    if (cnt == CNT_LAST) begin
                        cnt_n   = CNT_FULL;
                        state_n = LK_LOCKED;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            LK_LOCKED: begin
                if (too_wide) begin
                    cnt_n   = '0;
                    state_n = LK_HUNT;
                end
            end
        endcase
    end

    // output
    always_comb begin
        locked = (state == LK_LOCKED);
    end

endmodule

// File: rtl/pfd_out_stage.sv
module pfd_out_stage
    import pfd_steer_pkg::*;
(
    input  logic       pump_sel,
    input  logic       up_act,
    input  logic       dn_act,
    input  logic       locked,
    output logic       up_n,
    output logic       dn_n,
    output logic       pump_oe,
    output logic [1:0] pump_drive,
    output logic       phase_err,
    output logic       ld_pull_low
);
    logic  up_pulse_n;
    logic  dn_pulse_n;
    pump_t cmd;

    assign up_pulse_n = ~up_act;
    assign dn_pulse_n = ~dn_act;

    always_comb begin
        if (!pump_sel)              cmd = PUMP_IDLE;
        else if (up_act && !dn_act) cmd = PUMP_SOURCE;
        else if (dn_act && !up_act) cmd = PUMP_SINK;
        else                        cmd = PUMP_IDLE;
    end

    always_comb begin
        up_n        = pump_sel ? 1'b0 : up_pulse_n;
        dn_n        = pump_sel ? 1'b0 : dn_pulse_n;
        pump_oe     = pump_sel;
        pump_drive  = cmd;
        phase_err   = ~(up_pulse_n & dn_pulse_n);
        ld_pull_low = ~locked;
    end

endmodule

// File: rtl/pfd_steer.sv
module pfd_steer
    import pfd_steer_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RST_DLY     = 2,
    parameter int PW_W        = 8,
    parameter int LOCK_CYCLES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fc_in,
    input  logic            fp_in,
    input  logic            pump_sel,
    input  logic [PW_W-1:0] pulse_limit,
    output logic            up_n,
    output logic            dn_n,
    output logic            pump_oe,
    output logic [1:0]      pump_drive,
    output logic            phase_err,
    output logic            ld_pull_low
);
    localparam int N_CH = 2;

    logic [N_CH-1:0] raw_in;
    logic [N_CH-1:0] rise;
    logic            up_act, dn_act;
    logic            cmp_done, too_wide;
    logic            locked;

    assign raw_in = {fp_in, fc_in};

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_sync
        pfd_edge_sync #(
            .SYNC_STAGES(SYNC_STAGES)
        ) i_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[ch]),
            .rise (rise[ch])
        );
    end

    pfd_detector #(
        .RST_DLY(RST_DLY),
        .PW_W   (PW_W)
    ) i_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .fc_rise    (rise[0]),
        .fp_rise    (rise[1]),
        .pulse_limit(pulse_limit),
        .up_act     (up_act),
        .dn_act     (dn_act),
        .cmp_done   (cmp_done),
        .too_wide   (too_wide)
    );

    pfd_lock_filter #(
        .LOCK_CYCLES(LOCK_CYCLES)
    ) i_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_done(cmp_done),
        .too_wide(too_wide),
        .locked  (locked)
    );

    pfd_out_stage i_out (
        .pump_sel   (pump_sel),
        .up_act     (up_act),
        .dn_act     (dn_act),
        .locked     (locked),
        .up_n       (up_n),
        .dn_n       (dn_n),
        .pump_oe    (pump_oe),
        .pump_drive (pump_drive),
        .phase_err  (phase_err),
        .ld_pull_low(ld_pull_low)
    );

endmodule

// File: rtl/pfd_steer_checker.sv
module pfd_steer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pump_sel,
    input logic       up_n,
    input logic       dn_n,
    input logic       pump_oe,
    input logic [1:0] pump_drive,
    input logic       phase_err,
    input logic       ld_pull_low,
    input logic       cmp_done,
    input logic       too_wide
);
    a_r5_sel_forces_pins: assert property (@(posedge clk) disable iff (!rst_n)
        pump_sel |-> (!up_n && !dn_n && pump_oe));

    a_r6_pump_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pump_sel |-> (!pump_oe && pump_drive == 2'b00));

    a_r7_raw_matches_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !pump_sel |-> (phase_err == (!up_n || !dn_n)));

    a_r4_quiet_after_compare: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_done |=> !phase_err);

    a_r8_release_on_compare: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ld_pull_low) |-> $past(cmp_done));

    a_r9_wide_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
        too_wide |=> ld_pull_low);

    a_r10_legal_drive: assert property (@(posedge clk) disable iff (!rst_n)
        pump_drive != 2'b01);

endmodule

bind pfd_steer pfd_steer_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pump_sel   (pump_sel),
    .up_n       (up_n),
    .dn_n       (dn_n),
    .pump_oe    (pump_oe),
    .pump_drive (pump_drive),
    .phase_err  (phase_err),
    .ld_pull_low(ld_pull_low),
    .cmp_done   (cmp_done),
    .too_wide   (too_wide)
);

// File: tb/test_pfd_steer.sv
module test_pfd_steer;
    localparam int RST_DLY = 2;
    localparam int PW_W    = 8;
    localparam int LOCK_N  = 4;
    localparam int LIMIT   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fc_in = 1'b0;
    logic            fp_in = 1'b0;
    logic            pump_sel = 1'b0;
    logic [PW_W-1:0] pulse_limit = PW_W'(LIMIT);
    logic            up_n, dn_n, pump_oe, phase_err, ld_pull_low;
    logic [1:0]      pump_drive;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pfd_steer #(
        .SYNC_STAGES(2),
        .RST_DLY    (RST_DLY),
        .PW_W       (PW_W),
        .LOCK_CYCLES(LOCK_N)
    ) i_pfd_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .fc_in      (fc_in),
        .fp_in      (fp_in),
        .pump_sel   (pump_sel),
        .pulse_limit(pulse_limit),
        .up_n       (up_n),
        .dn_n       (dn_n),
        .pump_oe    (pump_oe),
        .pump_drive (pump_drive),
        .phase_err  (phase_err),
        .ld_pull_low(ld_pull_low)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One comparison: leader edge, gap cycles, follower edge; counts samples.
    task automatic run_cmp(input bit fc_first, input int gap, input bit sel,
                           output int up_lo, output int dn_lo,
                           output int src, output int snk, output int err_hi,
                           output int pins_hi, output int oe_bad);
        up_lo = 0; dn_lo = 0; src = 0; snk = 0; err_hi = 0; pins_hi = 0; oe_bad = 0;
        @(negedge clk);
        pump_sel = sel;
        if (fc_first) fc_in = 1'b1; else fp_in = 1'b1;
        if (gap == 0) begin fc_in = 1'b1; fp_in = 1'b1; end
        for (int i = 1; i <= gap + RST_DLY + 8; i++) begin
            @(negedge clk);
            if (!up_n) up_lo++;
            if (!dn_n) dn_lo++;
            if (up_n || dn_n) pins_hi++;
            if (pump_oe != sel) oe_bad++;
            if (pump_drive == 2'b11) src++;
            if (pump_drive == 2'b10) snk++;
            if (phase_err) err_hi++;
            if (i == gap) begin fc_in = 1'b1; fp_in = 1'b1; end
        end
        fc_in = 1'b0;
        fp_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 up_n", int'(up_n), 1);
        chk("R1 dn_n", int'(dn_n), 1);
        chk("R1 pump_oe", int'(pump_oe), 0);
        chk("R1 pump_drive", int'(pump_drive), 0);
        chk("R1 phase_err", int'(phase_err), 0);
        chk("R1 ld_pull_low", int'(ld_pull_low), 1);
    endtask

    task automatic t_pins_mode();
        int ul, dl, s, k, e, ph, ob;
        run_cmp(1'b1, 2, 1'b0, ul, dl, s, k, e, ph, ob);
        chk("R2 up width fc leads", ul, 2 + RST_DLY);
        chk("R4 dn overlap width", dl, RST_DLY);
        chk("R6 no pump cmd", s + k, 0);
        chk("R6 oe low", ob, 0);
        chk("R7 err width", e, 2 + RST_DLY);
        run_cmp(1'b0, 4, 1'b0, ul, dl, s, k, e, ph, ob);
        chk("R3 dn width fp leads", dl, 4 + RST_DLY);
        chk("R4 up overlap width", ul, RST_DLY);
        chk("R7 err width fp", e, 4 + RST_DLY);
        run_cmp(1'b1, 0, 1'b0, ul, dl, s, k, e, ph, ob);
        chk("R4 simultaneous up", ul, RST_DLY);
        chk("R4 simultaneous dn", dl, RST_DLY);
    endtask

    task automatic t_pump_mode();
        int ul, dl, s, k, e, ph, ob;
        run_cmp(1'b1, 3, 1'b1, ul, dl, s, k, e, ph, ob);
        chk("R5 pins held low", ph, 0);
        chk("R5 oe high", ob, 0);
        chk("R2 source cycles", s, 3);
        chk("R10 no sink when up leads", k, 0);
        chk("R7 err with sel high", e, 3 + RST_DLY);
        run_cmp(1'b0, 1, 1'b1, ul, dl, s, k, e, ph, ob);
        chk("R3 sink cycles", k, 1);
        chk("R10 no source when dn leads", s, 0);
        run_cmp(1'b1, 0, 1'b1, ul, dl, s, k, e, ph, ob);
        chk("R10 overlap is idle", s + k, 0);
        @(negedge clk);
        pump_sel = 1'b0;
    endtask

    task automatic t_lock();
        int ul, dl, s, k, e, ph, ob;
        run_cmp(1'b1, 6, 1'b0, ul, dl, s, k, e, ph, ob);
        chk("R9 wide lead unlocks", int'(ld_pull_low), 1);
        run_cmp(1'b1, 1, 1'b0, ul, dl, s, k, e, ph, ob);
        run_cmp(1'b0, LIMIT, 1'b0, ul, dl, s, k, e, ph, ob);
        run_cmp(1'b1, 0, 1'b0, ul, dl, s, k, e, ph, ob);
        chk("R8 held after three clean", int'(ld_pull_low), 1);
        run_cmp(1'b0, 2, 1'b0, ul, dl, s, k, e, ph, ob);
        chk("R8 released after four clean", int'(ld_pull_low), 0);
        run_cmp(1'b0, LIMIT + 1, 1'b0, ul, dl, s, k, e, ph, ob);
        chk("R9 over-limit lead relocks hunt", int'(ld_pull_low), 1);
        run_cmp(1'b1, 2, 1'b0, ul, dl, s, k, e, ph, ob);
        run_cmp(1'b1, 2, 1'b0, ul, dl, s, k, e, ph, ob);
        run_cmp(1'b1, 2, 1'b0, ul, dl, s, k, e, ph, ob);
        chk("R9 count restarted", int'(ld_pull_low), 1);
        run_cmp(1'b1, 2, 1'b0, ul, dl, s, k, e, ph, ob);
        chk("R8 released again", int'(ld_pull_low), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pins_mode();
        t_pump_mode();
        t_lock();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule